// File: doc/BRIEF.md
# Two-Channel Indirect Register Access Unit

This block sits between a narrow host bus and the configuration state of a two-channel serial controller. Each channel owns sixteen 8-bit control registers. The host reaches control register 0 and status register 0 directly. Every other register takes two steps: a write to register 0 loads a per-channel pointer, and the next access on that channel uses the register the pointer names. After that access the pointer drops back to zero on its own, so the next access again lands on register 0.

A separate data-select input bypasses the pointer. With it high, a write pushes the transmit FIFO and a read pops the receive FIFO, and the pointer is left as it was. Two control registers, the interrupt vector (index 2) and the interrupt control register (index 9), hold one value that both channels see and write. A shadow copy of register 7 takes register 7 writes while bit 0 of that channel's register 15 is set. The serial engines, interrupt logic and FIFO storage are outside the block. The block sees them only through the status inputs and the FIFO push and pop ports.

Top module: `sra_access`

## Requirements
- R1: On synchronous reset (`rst` high at a clock edge) every control register, both shadow registers, `rdata` and both pointers become zero.
- R2: A control write (`acc_data_sel`=0) while the channel's pointer is zero stores `wdata` in control register 0 of that channel. It also loads the pointer: bits 2:0 come from `wdata[2:0]`, and bit 3 is 1 exactly when `wdata[5:3]` equals 3'b001.
- R3: A control write while the pointer is nonzero stores `wdata` in the selected control register, and the pointer returns to zero.
- R4: A control read while the pointer is nonzero returns, one cycle later on `rdata`, status byte k of that channel (status input bits 8k+7:8k) for pointer value k. The pointer then returns to zero.
- R5: A control read while the pointer is zero returns status byte 0 of that channel, with no pointer setup needed.
- R6: A write with `acc_data_sel`=1 raises `tx_push` in the same cycle with `tx_data`=`wdata`. It changes no control register and leaves both pointers unchanged.
- R7: A read with `acc_data_sel`=1 raises `rx_pop` in the same cycle and puts `rx_data` on `rdata` one cycle later. Both pointers are left unchanged.
- R8: Control registers 2 and 9 are one shared value. A write from either channel shows up at the same index in both `cfg_a` and `cfg_b`.
- R9: While bit 0 of a channel's control register 15 is 1, a write to index 7 on that channel goes to that channel's shadow register and leaves register 7 unchanged. While the bit is 0, the write goes to register 7.
- R10: Each channel has its own pointer. Accesses on one channel neither use nor clear the other channel's pointer.
- R11: A control read of a pointer value at or above `RD_REGS` (default 6) returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | One-cycle access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_chan | input | 1 | Channel select, 0 = A, 1 = B |
| acc_data_sel | input | 1 | 1 = FIFO data access, 0 = control access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered, held until the next read |
| stat_a | input | 8*RD_REGS | Channel A status bytes, byte k at bits 8k+7:8k |
| stat_b | input | 8*RD_REGS | Channel B status bytes |
| rx_data | input | 8 | Head of the receive FIFO |
| rx_pop | output | 1 | Receive FIFO pop |
| tx_push | output | 1 | Transmit FIFO push |
| tx_data | output | 8 | Transmit FIFO write data |
| cfg_a | output | 128 | Channel A control registers, register i at bits 8i+7:8i |
| cfg_b | output | 128 | Channel B control registers |
| shadow_a | output | 8 | Channel A shadow of register 7 |
| shadow_b | output | 8 | Channel B shadow of register 7 |

## Verification
The bench targets cases where the pointer is cleared too late, cleared too often, or cleared at the wrong time. One case is a FIFO access placed between pointer load and use: a design that clears on it would send the following write to register 0. Another is an access on the other channel in the same gap: a single shared pointer would land that write in the wrong register. Shared registers are written from one channel and read on the other, which catches a design that keeps two copies. The shadow register is exercised with the enable bit set and clear, which catches a design that writes both targets or ignores the gate. Pointer values past the implemented status bytes must read as zero and must not alias a real byte.

// File: rtl/sra_pkg.sv
package sra_pkg;
    localparam int NREG = 16;
    localparam int DW   = 8;
    localparam int PW   = $clog2(NREG);

    typedef logic [DW-1:0] byte_t;
    typedef logic [PW-1:0] ptr_t;

    localparam logic [2:0] CMD_HIGH = 3'b001;
    localparam ptr_t IDX_VEC = ptr_t'(2);
    localparam ptr_t IDX_CTL = ptr_t'(9);
    localparam ptr_t IDX_SH  = ptr_t'(7);
    localparam ptr_t IDX_EN  = ptr_t'(15);

    function automatic logic is_shared(ptr_t i);
        return (i == IDX_VEC) || (i == IDX_CTL);
    endfunction
endpackage

// File: rtl/sra_ptr.sv
module sra_ptr
    import sra_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc,
    input  logic  wr,
    input  byte_t wdata,
    output ptr_t  ptr_q
);
    typedef struct packed {
        ptr_t ptr;
    } ptr_st_t;

    ptr_st_t d, q;

    always_comb begin
        d = q;
        if (acc) begin
            if (wr && q.ptr == '0)
                d.ptr = {wdata[5:3] == CMD_HIGH, wdata[2:0]};
            else
                d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign ptr_q = q.ptr;

    // R3
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        acc && q.ptr != '0 |=> q.ptr == '0);
    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        acc && wr && q.ptr == '0 |=> q.ptr[2:0] == $past(wdata[2:0]));
endmodule

// File: rtl/sra_regfile.sv
module sra_regfile
    import sra_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic                             chan,
    input  ptr_t                             idx,
    input  byte_t                            wdata,
    output logic [1:0][NREG-1:0][DW-1:0]     regs_o,
    output logic [1:0][DW-1:0]               shadow_o
);
    typedef struct packed {
        logic [1:0][NREG-1:0][DW-1:0] regs;
        logic [1:0][DW-1:0]           sh;
    } rf_st_t;

    rf_st_t d, q;

    always_comb begin
        d = q;
        if (we) begin
            if (is_shared(idx)) begin
                d.regs[0][idx] = wdata;
                d.regs[1][idx] = wdata;
            end else if (idx == IDX_SH && q.regs[chan][IDX_EN][0]) begin
                d.sh[chan] = wdata;
            end else begin
                d.regs[chan][idx] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign regs_o   = q.regs;
    assign shadow_o = q.sh;

    // R9
    shadow_guard_a_chk: assert property (@(posedge clk) disable iff (rst)
        we && !chan && idx == IDX_SH && q.regs[0][IDX_EN][0] |=> $stable(q.regs[0][IDX_SH]));
    // R9
    shadow_guard_b_chk: assert property (@(posedge clk) disable iff (rst)
        we && chan && idx == IDX_SH && q.regs[1][IDX_EN][0] |=> $stable(q.regs[1][IDX_SH]));
    // R8
    shared_sync_chk: assert property (@(posedge clk) disable iff (rst)
        regs_o[0][IDX_VEC] == regs_o[1][IDX_VEC] && regs_o[0][IDX_CTL] == regs_o[1][IDX_CTL]);
endmodule

// File: rtl/sra_access.sv
module sra_access
    import sra_pkg::*;
#(
    parameter int RD_REGS = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_en,
    input  logic                    acc_wr,
    input  logic                    acc_chan,
    input  logic                    acc_data_sel,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    input  logic [RD_REGS*DW-1:0]   stat_a,
    input  logic [RD_REGS*DW-1:0]   stat_b,
    input  logic [DW-1:0]           rx_data,
    output logic                    rx_pop,
    output logic                    tx_push,
    output logic [DW-1:0]           tx_data,
    output logic [NREG*DW-1:0]      cfg_a,
    output logic [NREG*DW-1:0]      cfg_b,
    output logic [DW-1:0]           shadow_a,
    output logic [DW-1:0]           shadow_b
);
    typedef struct packed {
        byte_t rdata;
    } top_st_t;

    top_st_t d, q;

    logic [1:0]                   ctl_acc;
    ptr_t [1:0]                   ptr;
    logic [1:0][NREG-1:0][DW-1:0] regs;
    logic [1:0][DW-1:0]           shad;
    ptr_t                         sel_ptr;
    logic [RD_REGS*DW-1:0]        sel_stat;
    byte_t                        rd_val;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        assign ctl_acc[c] = acc_en && !acc_data_sel && (acc_chan == c[0]);
        sra_ptr u_ptr (
            .clk   (clk),
            .rst   (rst),
            .acc   (ctl_acc[c]),
            .wr    (acc_wr),
            .wdata (wdata),
            .ptr_q (ptr[c])
        );
    end

    assign sel_ptr  = ptr[acc_chan];
    assign sel_stat = acc_chan ? stat_b : stat_a;

    sra_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .we       (acc_en && acc_wr && !acc_data_sel),
        .chan     (acc_chan),
        .idx      (sel_ptr),
        .wdata    (wdata),
        .regs_o   (regs),
        .shadow_o (shad)
    );

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < RD_REGS; k++) begin
            if (sel_ptr == ptr_t'(k)) rd_val = sel_stat[k*DW +: DW];
        end
    end

    always_comb begin
        d = q;
        if (acc_en && !acc_wr) begin
            if (acc_data_sel) d.rdata = rx_data;
            else              d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign rdata    = q.rdata;
    assign rx_pop   = acc_en && !acc_wr && acc_data_sel;
    assign tx_push  = acc_en && acc_wr && acc_data_sel;
    assign tx_data  = wdata;
    assign cfg_a    = regs[0];
    assign cfg_b    = regs[1];
    assign shadow_a = shad[0];
    assign shadow_b = shad[1];

    // R6
    fifo_keeps_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && acc_data_sel |=> $stable(ptr));
    // R7
    rx_capture_chk: assert property (@(posedge clk) disable iff (rst)
        rx_pop |=> rdata == $past(rx_data));
    // R5
    direct_status_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en && !acc_wr && !acc_data_sel && sel_ptr == '0 |=> rdata == $past(sel_stat[DW-1:0]));
endmodule

// File: tb/sra_access_tb.sv
module sra_access_tb;
    localparam int RD = 6;

    logic clk = 0, rst = 1;
    logic acc_en = 0, acc_wr = 0, acc_chan = 0, acc_data_sel = 0;
    logic [7:0] wdata = 0, rx_data = 0;
    logic [RD*8-1:0] stat_a = 0, stat_b = 0;
    logic [7:0] rdata, tx_data, shadow_a, shadow_b;
    logic rx_pop, tx_push;
    logic [127:0] cfg_a, cfg_b;

    int total = 0, bad = 0, cyc = 0;

    logic [7:0] mreg [2][16];
    logic [7:0] msh  [2];
    logic [3:0] mptr [2];

    sra_access #(.RD_REGS(RD)) u_dut (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_chan(acc_chan),
        .acc_data_sel(acc_data_sel), .wdata(wdata), .rdata(rdata), .stat_a(stat_a),
        .stat_b(stat_b), .rx_data(rx_data), .rx_pop(rx_pop), .tx_push(tx_push),
        .tx_data(tx_data), .cfg_a(cfg_a), .cfg_b(cfg_b), .shadow_a(shadow_a), .shadow_b(shadow_b)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL R1 watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] flat(input int c);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = mreg[c][i];
        return v;
    endfunction

    function automatic logic [7:0] exp_stat(input int c, input logic [3:0] p);
        if (int'(p) >= RD) return 8'h00;
        return c ? stat_b[p*8 +: 8] : stat_a[p*8 +: 8];
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            msh[c] = 0; mptr[c] = 0;
            for (int i = 0; i < 16; i++) mreg[c][i] = 0;
        end
    endtask

    // one access; tag names the requirement under test
    task automatic op(input bit wr, input bit c, input bit ds, input logic [7:0] dat, input string tag);
        logic [7:0] er;
        logic [3:0] p;
        er = 0;
        @(negedge clk);
        acc_en = 1; acc_wr = wr; acc_chan = c; acc_data_sel = ds; wdata = dat;
        rx_data = 8'($urandom);
        #1;
        chk({tag, " push"}, {127'd0, tx_push}, {127'd0, wr && ds});
        chk({tag, " pop"},  {127'd0, rx_pop},  {127'd0, !wr && ds});
        if (wr && ds) chk({tag, " txdata"}, {120'd0, tx_data}, {120'd0, dat});
        p = mptr[c];
        if (ds) begin
            if (!wr) er = rx_data;
        end else if (wr) begin
            if (p == 0) begin
                mreg[c][0] = dat;
                mptr[c] = {dat[5:3] == 3'b001, dat[2:0]};
            end else begin
                if (p == 2 || p == 9) begin
                    mreg[0][p] = dat; mreg[1][p] = dat;
                end else if (p == 7 && mreg[c][15][0]) msh[c] = dat;
                else mreg[c][p] = dat;
                mptr[c] = 0;
            end
        end else begin
            er = exp_stat(c, p);
            mptr[c] = 0;
        end
        @(posedge clk);
        #2;
        acc_en = 0;
        if (!wr) chk({tag, " rdata"}, {120'd0, rdata}, {120'd0, er});
        chk({tag, " cfg_a"}, cfg_a, flat(0));
        chk({tag, " cfg_b"}, cfg_b, flat(1));
        chk({tag, " shadow"}, {112'd0, shadow_a, shadow_b}, {112'd0, msh[0], msh[1]});
    endtask

    // pointer write code that selects register r
    function automatic logic [7:0] pw(input int r);
        return {2'b00, (r >= 8) ? 3'b001 : 3'b000, 3'(r)};
    endfunction

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < RD; k++) begin
            stat_a[k*8 +: 8] = 8'(8'h10 + k);
            stat_b[k*8 +: 8] = 8'(8'hA0 + k);
        end
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst = 0;
        chk("R1 reset cfg_a", cfg_a, 128'd0);
        chk("R1 reset cfg_b", cfg_b, 128'd0);
        chk("R1 reset rd/sh", {112'd0, rdata, shadow_a}, 128'd0);
        op(0, 0, 0, 0, "R1 R5 status0 after reset");
        op(0, 1, 0, 0, "R5 status0 B");
        op(1, 0, 0, pw(12), "R2 high pointer");
        op(1, 0, 0, 8'h5C, "R3 write reg12");
        op(1, 0, 0, 8'h33, "R3 reg0 again");
        op(1, 1, 0, pw(3), "R2 pointer 3");
        op(0, 1, 0, 0, "R4 read stat 3");
        op(0, 1, 0, 0, "R4 pointer cleared");
        op(1, 0, 0, pw(14), "R11 pointer 14");
        op(0, 0, 0, 0, "R11 unimplemented read");
        op(1, 1, 0, pw(9), "R8 ptr 9 on B");
        op(1, 1, 0, 8'hC9, "R8 shared write B");
        op(1, 0, 0, pw(2), "R8 ptr 2 on A");
        op(1, 0, 0, 8'h2E, "R8 shared write A");
        op(1, 1, 0, pw(7), "R9 ptr 7 gate off");
        op(1, 1, 0, 8'h77, "R9 reg7 direct");
        op(1, 0, 0, pw(15), "R9 ptr 15");
        op(1, 0, 0, 8'h01, "R9 enable shadow");
        op(1, 0, 0, pw(7), "R9 ptr 7 gate on");
        op(1, 0, 0, 8'hE7, "R9 shadow write");
        op(1, 0, 0, pw(5), "R6 ptr 5");
        op(1, 0, 1, 8'h99, "R6 fifo push");
        op(0, 0, 1, 0, "R7 fifo pop");
        op(1, 0, 0, 8'h55, "R6 R7 ptr kept");
        op(1, 0, 0, pw(4), "R10 ptr A");
        op(1, 1, 0, 8'h40, "R10 B reg0");
        op(1, 1, 0, 8'h41, "R10 B second");
        op(1, 0, 0, 8'h4A, "R10 A uses ptr");
        for (int n = 0; n < 3000; n++) begin
            bit w, c, ds;
            logic [7:0] dd;
            string t;
            w = 1'($urandom); c = 1'($urandom); ds = ($urandom % 5) == 0;
            dd = 8'($urandom);
            if (mptr[c] == 0 && w && !ds) dd[5:3] = ($urandom % 2) ? 3'b001 : 3'(dd[5:3]);
            if (ds) t = w ? "R6 rnd" : "R7 rnd";
            else if (mptr[c] == 0) t = w ? "R2 rnd" : "R5 rnd";
            else if (w) t = (mptr[c] == 2 || mptr[c] == 9) ? "R8 rnd" : (mptr[c] == 7 ? "R9 rnd" : "R3 rnd");
            else t = (int'(mptr[c]) >= RD) ? "R11 rnd" : "R4 rnd";
            if (n % 500 == 0) begin
                stat_a = {RD{8'($urandom)}} ^ stat_a;
                stat_b = {RD{8'($urandom)}} ^ stat_b;
            end
            op(w, c, ds, dd, t);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule